// File: doc/BRIEF.md
# Renamed Descriptor Pool Allocator

This block lets several versions of binding state be in flight at once while they all draw on one shared pool of physical descriptor entries. A version ("set") is built by binding logical slots. Each bind takes a free physical entry from the pool and records which entry that slot now points at. When the build set is committed, it becomes resident and a new build set opens. The new set starts out with every mapping of the set it came from. Those mappings are shared, not copied, so a commit uses no pool entries.

Resident sets retire in the order they were committed. An entry goes back to the pool only when no live set still points at it. When the pool is empty, binds stall until an older set retires. A lookup port turns a (set, logical slot) pair into a physical index in the same cycle.

Top module: `descriptor_rename_pool`

## Requirements
- R1: After reset every pool entry is free and the build set is 0. No (set, slot) pair looks up as mapped. `bind_ready` is 1 with `bind_phys` = 0, `commit_ready` is 1 and `retire_ready` is 0.
- R2: While `bind_ready` is 1, `bind_phys` shows the lowest-numbered free pool entry. An accepted bind maps the slot in the build set to that entry, and the entry is no longer free from the next cycle.
- R3: The pool holds POOL entries (default 128), and each entry is mapped by at most one slot of any set. With no entry free, `bind_ready` is 0 and a bind request leaves every mapping unchanged.
- R4: An accepted commit advances `build_set` by one, wrapping from SETS-1 to 0. The new build set looks up exactly as the committed set did, and the commit claims no pool entries.
- R5: Rebinding a slot in the build set changes only that set's mapping. Resident sets keep the entry they had.
- R6: An entry is freed only when no live set maps it. Replacing a mapping that only the build set holds frees the old entry from the next cycle. Replacing one that a resident set shares does not free it.
- R7: An accepted retire releases the oldest resident set in commit order. From the next cycle its slots look up as unmapped, and entries that it alone held are free.
- R8: `commit_ready` is 0 when SETS-1 sets are resident. `retire_ready` is 0 when no set is resident. `bind_ready` is 0 in any cycle where `commit_valid` is 1.
- R9: `look_hit` and `look_phys` follow `look_set` and `look_slot` in the same cycle, without a clock edge. `look_hit` = 1 means mapped, and `look_phys` is meaningful only then.
- R10: A commit or retire request made while its ready is 0 has no effect: `build_set` and all mappings stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bind_valid | input | 1 | Request to bind a slot of the build set |
| bind_slot | input | $clog2(SLOTS) | Logical slot to bind |
| bind_ready | output | 1 | Bind accepted this cycle when high together with bind_valid |
| bind_phys | output | $clog2(POOL) | Pool entry a bind would take now |
| commit_valid | input | 1 | Request to make the build set resident |
| commit_ready | output | 1 | Commit accepted when high together with commit_valid |
| build_set | output | $clog2(SETS) | Id of the set being built |
| retire_valid | input | 1 | Request to release the oldest resident set |
| retire_ready | output | 1 | Retire accepted when high together with retire_valid |
| look_set | input | $clog2(SETS) | Set id to look up |
| look_slot | input | $clog2(SLOTS) | Logical slot to look up |
| look_hit | output | 1 | Looked-up slot is mapped |
| look_phys | output | $clog2(POOL) | Pool entry of the looked-up slot |

## Verification
The properties assume that `bind_slot` and `look_set` stay inside the configured ranges, and that SETS is a power of two so every set id names a real set. They also assume that request inputs hold known values from the first edge after reset. The bench derives every slot and set index by masking a counter or a shift-register value to these widths. It changes requests only on falling edges, so each request is seen whole at the next rising edge. It issues bind and commit together only on purpose, to show that the commit takes precedence.

// File: rtl/drp_pkg.sv
package drp_pkg;

  // advance a ring index of n positions by one
  function automatic int unsigned ring_step(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/drp_free_pick.sv
module drp_free_pick #(
  parameter int POOL = 128,
  localparam int PHYS_W = $clog2(POOL)
) (
  input  logic [POOL-1:0]   free_vec,
  output logic              any_free,
  output logic [PHYS_W-1:0] pick_idx
);

  // lowest-numbered free entry wins
  always_comb begin
    pick_idx = '0;
    any_free = 1'b0;
    for (int i = POOL - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        pick_idx = PHYS_W'(i);
        any_free = 1'b1;
      end
    end
  end

endmodule

// File: rtl/drp_set_ring.sv
module drp_set_ring #(
  parameter int SETS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int CNT_W = $clog2(SETS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_req,
  input  logic             retire_req,
  output logic             commit_ok,
  output logic             retire_ok,
  output logic             commit_fire,
  output logic             retire_fire,
  output logic [SET_W-1:0] build_id,
  output logic [SET_W-1:0] oldest_id,
  output logic [CNT_W-1:0] live_count
);

  assign commit_ok   = live_count < CNT_W'(SETS - 1);
  assign retire_ok   = live_count != '0;
  assign commit_fire = commit_req & commit_ok;
  assign retire_fire = retire_req & retire_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      build_id   <= '0;
      oldest_id  <= '0;
      live_count <= '0;
    end else begin
      if (commit_fire)
        build_id <= SET_W'(drp_pkg::ring_step(32'(build_id), SETS));
      if (retire_fire)
        oldest_id <= SET_W'(drp_pkg::ring_step(32'(oldest_id), SETS));
      case ({commit_fire, retire_fire})
        2'b10:   live_count <= live_count + 1'b1;
        2'b01:   live_count <= live_count - 1'b1;
        default: live_count <= live_count;
      endcase
    end
  end

endmodule

// File: rtl/drp_map_table.sv
module drp_map_table #(
  parameter int POOL  = 128,
  parameter int SETS  = 4,
  parameter int SLOTS = 32,
  localparam int PHYS_W = $clog2(POOL),
  localparam int SET_W  = $clog2(SETS),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  build_id,
  input  logic [SET_W-1:0]  next_id,
  input  logic [SET_W-1:0]  oldest_id,
  input  logic              bind_fire,
  input  logic [SLOT_W-1:0] bind_slot,
  input  logic [PHYS_W-1:0] alloc_idx,
  input  logic              commit_fire,
  input  logic              retire_fire,
  input  logic [SET_W-1:0]  look_set,
  input  logic [SLOT_W-1:0] look_slot,
  output logic              look_hit,
  output logic [PHYS_W-1:0] look_phys,
  output logic [POOL-1:0]   free_vec
);

  logic              map_v [SETS][SLOTS];
  logic [PHYS_W-1:0] map_p [SETS][SLOTS];
  // per-set reference bitmap: bit p set when the set maps entry p
  logic [POOL-1:0]   holds [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        holds[s] <= '0;
        for (int k = 0; k < SLOTS; k++) begin
          map_v[s][k] <= 1'b0;
          map_p[s][k] <= '0;
        end
      end
    end else begin
      if (retire_fire) begin
        holds[oldest_id] <= '0;
        for (int k = 0; k < SLOTS; k++) map_v[oldest_id][k] <= 1'b0;
      end
      if (bind_fire) begin
        if (map_v[build_id][bind_slot])
          holds[build_id][map_p[build_id][bind_slot]] <= 1'b0;
        holds[build_id][alloc_idx]   <= 1'b1;
        map_v[build_id][bind_slot]   <= 1'b1;
        map_p[build_id][bind_slot]   <= alloc_idx;
      end
      if (commit_fire) begin
        holds[next_id] <= holds[build_id];
        for (int k = 0; k < SLOTS; k++) begin
          map_v[next_id][k] <= map_v[build_id][k];
          map_p[next_id][k] <= map_p[build_id][k];
        end
      end
    end
  end

  always_comb begin
    logic [POOL-1:0] used;
    used = '0;
    for (int s = 0; s < SETS; s++) used = used | holds[s];
    free_vec = ~used;
  end

  assign look_hit  = map_v[look_set][look_slot];
  assign look_phys = map_p[look_set][look_slot];

endmodule

// File: rtl/descriptor_rename_pool.sv
module descriptor_rename_pool #(
  parameter int POOL  = 128,
  parameter int SETS  = 4,
  parameter int SLOTS = 32,
  localparam int PHYS_W = $clog2(POOL),
  localparam int SET_W  = $clog2(SETS),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SETS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bind_valid,
  input  logic [SLOT_W-1:0] bind_slot,
  output logic              bind_ready,
  output logic [PHYS_W-1:0] bind_phys,
  input  logic              commit_valid,
  output logic              commit_ready,
  output logic [SET_W-1:0]  build_set,
  input  logic              retire_valid,
  output logic              retire_ready,
  input  logic [SET_W-1:0]  look_set,
  input  logic [SLOT_W-1:0] look_slot,
  output logic              look_hit,
  output logic [PHYS_W-1:0] look_phys
);

  // named internal events for the checker
  logic              free_any;
  logic [PHYS_W-1:0] alloc_idx;
  logic              alloc_fire;
  logic [POOL-1:0]   free_vec;
  logic              commit_fire;
  logic              retire_fire;
  logic [SET_W-1:0]  oldest_id;
  logic [SET_W-1:0]  next_id;
  logic [CNT_W-1:0]  live_count;

  drp_set_ring #(.SETS(SETS)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_req (commit_valid),
    .retire_req (retire_valid),
    .commit_ok  (commit_ready),
    .retire_ok  (retire_ready),
    .commit_fire(commit_fire),
    .retire_fire(retire_fire),
    .build_id   (build_set),
    .oldest_id  (oldest_id),
    .live_count (live_count)
  );

  assign next_id = SET_W'(drp_pkg::ring_step(32'(build_set), SETS));

  drp_free_pick #(.POOL(POOL)) u_pick (
    .free_vec(free_vec),
    .any_free(free_any),
    .pick_idx(alloc_idx)
  );

  // a commit request takes the cycle; binds wait
  assign bind_ready = free_any & ~commit_valid;
  assign bind_phys  = alloc_idx;
  assign alloc_fire = bind_valid & bind_ready;

  drp_map_table #(.POOL(POOL), .SETS(SETS), .SLOTS(SLOTS)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .build_id   (build_set),
    .next_id    (next_id),
    .oldest_id  (oldest_id),
    .bind_fire  (alloc_fire),
    .bind_slot  (bind_slot),
    .alloc_idx  (alloc_idx),
    .commit_fire(commit_fire),
    .retire_fire(retire_fire),
    .look_set   (look_set),
    .look_slot  (look_slot),
    .look_hit   (look_hit),
    .look_phys  (look_phys),
    .free_vec   (free_vec)
  );

endmodule

// File: rtl/drp_checker.sv
module drp_checker #(
  parameter int POOL = 128,
  parameter int SETS = 4,
  localparam int PHYS_W = $clog2(POOL),
  localparam int SET_W  = $clog2(SETS),
  localparam int CNT_W  = $clog2(SETS) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_fire,
  input logic [PHYS_W-1:0] alloc_idx,
  input logic [POOL-1:0]   free_vec,
  input logic              commit_fire,
  input logic [SET_W-1:0]  build_set,
  input logic [CNT_W-1:0]  live_count,
  input logic              bind_ready,
  input logic              commit_ready,
  input logic              retire_ready
);

  AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> free_vec[alloc_idx]); // R2
  AST_ALLOC_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> !free_vec[$past(alloc_idx)]); // R2
  AST_EMPTY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (free_vec == '0) |-> !bind_ready); // R3
  AST_BUILD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> build_set == SET_W'(drp_pkg::ring_step(32'($past(build_set)), SETS))); // R4
  AST_BUILD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(build_set)); // R10
  AST_LIVE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    live_count <= CNT_W'(SETS - 1)); // R8
  AST_RETIRE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (live_count == '0) |-> !retire_ready); // R8
  AST_COMMIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (live_count == CNT_W'(SETS - 1)) |-> !commit_ready); // R8

endmodule

bind descriptor_rename_pool drp_checker #(.POOL(POOL), .SETS(SETS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_fire  (alloc_fire),
  .alloc_idx   (alloc_idx),
  .free_vec    (free_vec),
  .commit_fire (commit_fire),
  .build_set   (build_set),
  .live_count  (live_count),
  .bind_ready  (bind_ready),
  .commit_ready(commit_ready),
  .retire_ready(retire_ready)
);

// File: tb/descriptor_rename_pool_test.sv
module descriptor_rename_pool_test;
  localparam int POOL = 128;
  localparam int SETS = 4;
  localparam int SLOTS = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bind_valid = 1'b0;
  logic [4:0] bind_slot = '0;
  logic       bind_ready;
  logic [6:0] bind_phys;
  logic       commit_valid = 1'b0;
  logic       commit_ready;
  logic [1:0] build_set;
  logic       retire_valid = 1'b0;
  logic       retire_ready;
  logic [1:0] look_set = '0;
  logic [4:0] look_slot = '0;
  logic       look_hit;
  logic [6:0] look_phys;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  bit own [SETS][POOL];
  bit mv  [SETS][SLOTS];
  int mp  [SETS][SLOTS];
  int m_bld = 0, m_old = 0, m_live = 0;

  always #4 clk = ~clk;

  descriptor_rename_pool #(.POOL(POOL), .SETS(SETS), .SLOTS(SLOTS)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_lowest();
    for (int p = 0; p < POOL; p++) begin
      bit used = 0;
      for (int s = 0; s < SETS; s++) used |= own[s][p];
      if (!used) return p;
    end
    return -1;
  endfunction

  function automatic void m_bind(input int slot, input int e);
    if (mv[m_bld][slot]) own[m_bld][mp[m_bld][slot]] = 0;
    own[m_bld][e] = 1;
    mv[m_bld][slot] = 1;
    mp[m_bld][slot] = e;
  endfunction

  function automatic void m_commit();
    int nb = (m_bld + 1) % SETS;
    for (int p = 0; p < POOL; p++) own[nb][p] = own[m_bld][p];
    for (int k = 0; k < SLOTS; k++) begin mv[nb][k] = mv[m_bld][k]; mp[nb][k] = mp[m_bld][k]; end
    m_bld = nb;
    m_live++;
  endfunction

  function automatic void m_retire();
    for (int p = 0; p < POOL; p++) own[m_old][p] = 0;
    for (int k = 0; k < SLOTS; k++) mv[m_old][k] = 0;
    m_old = (m_old + 1) % SETS;
    m_live--;
  endfunction

  // one request cycle; called at a falling edge
  task automatic op(input bit b, input bit c, input bit r, input int slot, input string tag);
    int ef;
    bit eb, ec, er;
    bind_valid = b; commit_valid = c; retire_valid = r; bind_slot = 5'(slot);
    #1;
    ef = m_lowest();
    ec = (m_live < SETS - 1);
    er = (m_live > 0);
    eb = (ef >= 0) && !c;
    chk(commit_ready === ec, "R8", int'(commit_ready), int'(ec));
    chk(retire_ready === er, "R8", int'(retire_ready), int'(er));
    chk(bind_ready === eb, "R3", int'(bind_ready), int'(eb));
    if (eb) chk(bind_phys == 7'(ef), tag, int'(bind_phys), ef);
    chk(build_set == 2'(m_bld), "R4", int'(build_set), m_bld);
    @(posedge clk);
    if (r && er) m_retire();
    if (b && eb) m_bind(slot, ef);
    if (c && ec) m_commit();
    @(negedge clk);
    bind_valid = 0; commit_valid = 0; retire_valid = 0;
  endtask

  // combinational lookup sweep over every (set, slot); R9
  task automatic sweep(input string tag);
    for (int s = 0; s < SETS; s++) begin
      for (int k = 0; k < SLOTS; k++) begin
        look_set = 2'(s); look_slot = 5'(k);
        #1;
        chk(look_hit === mv[s][k], tag, int'(look_hit), int'(mv[s][k]));
        if (mv[s][k]) chk(look_phys == 7'(mp[s][k]), tag, int'(look_phys), mp[s][k]);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bind_ready === 1'b1, "R1", int'(bind_ready), 1);
    chk(bind_phys == 7'd0, "R1", int'(bind_phys), 0);
    chk(commit_ready === 1'b1, "R1", int'(commit_ready), 1);
    chk(retire_ready === 1'b0, "R1", int'(retire_ready), 0);
    chk(build_set == 2'd0, "R1", int'(build_set), 0);
    sweep("R1");

    // R2 fresh binds in set 0
    for (int k = 0; k < 10; k++) op(1, 0, 0, k, "R2");
    sweep("R2");
    // R4 commit: inherited mappings, nothing claimed
    op(0, 1, 0, 0, "R4");
    chk(build_set == 2'd1, "R4", int'(build_set), 1);
    chk(bind_phys == 7'd10, "R4", int'(bind_phys), 10);
    sweep("R4");
    // R5/R6 rebinding
    op(1, 0, 0, 3, "R5");
    sweep("R5");
    op(1, 0, 0, 3, "R6");
    chk(bind_phys == 7'd10, "R6", int'(bind_phys), 10);
    op(1, 0, 0, 20, "R6");
    sweep("R6");
    // R8/R10 commit gate
    op(0, 1, 0, 0, "R4");
    op(0, 1, 0, 0, "R4");
    op(0, 1, 0, 0, "R10");
    chk(build_set == 2'd3, "R10", int'(build_set), 3);
    // R8 bind blocked while commit requested
    op(1, 1, 0, 7, "R8");
    sweep("R10");
    // R7 retire oldest
    op(0, 0, 1, 0, "R7");
    chk(bind_phys == 7'd3, "R7", int'(bind_phys), 3);
    sweep("R7");
    while (m_live > 0) op(0, 0, 1, 0, "R7");
    op(0, 0, 1, 0, "R10");
    sweep("R7");

    // R3 fill the whole pool
    for (int g = 0; g < SETS; g++) begin
      for (int k = 0; k < SLOTS; k++) op(1, 0, 0, k, "R3");
      if (g < SETS - 1) op(0, 1, 0, 0, "R4");
    end
    chk(bind_ready === 1'b0, "R3", int'(bind_ready), 0);
    op(1, 0, 0, 5, "R3");
    sweep("R3");
    op(0, 0, 1, 0, "R7");
    chk(bind_ready === 1'b1, "R7", int'(bind_ready), 1);
    sweep("R7");

    // mixed request stream
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[2:0])
        3'd5:    op(0, 1, 0, 0, "R4");
        3'd6:    op(0, 0, 1, 0, "R7");
        3'd7:    op(0, 1, 1, 0, "R8");
        default: op(1, 0, 0, int'(lf[12:8]), "R2");
      endcase
      if (n % 100 == 99) sweep("R9");
    end
    sweep("R9");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule